// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This block is a memory-mapped timer with four independent down-counters that share one register bus and one interrupt output. Every channel has a counter, a background load value that is used only when the counter wraps in periodic mode, and a control register. The control register sets the enable, the run mode, the prescale ratio and the counter width. Software that wants a rising timebase reads the count and complements it.

The bus is a plain, single-cycle register port. A write is taken on the rising clock edge on which `bus_wr` is high. Read data is a combinational function of `bus_addr`. There is no handshake or back-pressure: every access completes in the cycle in which it is presented. A counter that reaches zero sets its channel's raw interrupt bit. One interrupt line reports any raw bit whose mask bit is set.

Top module: `quad_dtimer`

## Requirements
- R1: Byte addresses with bits 1:0 at zero select registers. 0x00 is the interrupt mask (read/write, bit n for channel n), 0x04 is raw status, 0x08 is masked status, and 0x0C is clear (reads 0). Channel n sits at 0x10+0x10*n: load at +0x0 (reads the current count), count at +0x4, control at +0x8 and background load at +0xC. Every other address reads zero.
- R2: A write to a channel's load register sets the count at that edge and also copies the value into the background load register. A write to the background load register alone leaves the running count unchanged.
- R3: An enabled counter drops by one on each prescaled tick. Control bits 3:2 select the ratio: 00 is divide by 1, 01 is divide by 16, and 10 or 11 is divide by 256. After an enable or load write at edge E, the ticks fall on edges E+D, E+2D and so on, where D is the divide ratio.
- R4: With control bit 6 (periodic) and bit 0 (one-shot) both clear, a tick at count zero wraps the counter to all ones of its width.
- R5: With bit 6 set and bit 0 clear, a tick at count zero reloads the background load value.
- R6: With bit 0 set (this takes priority over bit 6), the counter stops at zero and clears enable bit 7 on the same edge. The other control bits read back unchanged.
- R7: Control bit 1 set selects 32-bit counting. When bit 1 is clear, only the low 16 bits count and wrap, and bits 31:16 of the count read as zero.
- R8: A tick that takes a counter from 1 to 0, or a tick at 0 in one-shot mode, sets raw status bit n. Writes to the raw status address have no effect.
- R9: Masked status equals raw AND mask. `irq_o` is high exactly when some masked bit is set.
- R10: Writing 1 to bit n of the clear register clears raw bit n. Zero bits leave raw bits as they are. An event on the same edge keeps its raw bit set.
- R11: After reset, all registers read zero, every counter is stopped and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | OR of the masked interrupt status bits |

## Verification
The bound checker watches several rules on every cycle. A zero event always shows up in the raw status on the next edge, and a clear write without a competing event always removes the bit. The interrupt line stays low while the mask is empty. A one-shot channel that drops its own enable has a count of exactly zero, and a 16-bit channel never shows upper count bits on the bus. The bench scenarios are needed for the rest, because those rules depend on values and cycle counts. They cover the exact tick edges under each prescale ratio, the wrap values in free-running and periodic modes, the copy into the background register on a load, and the way the one-shot bit overrides the periodic bit.

// File: rtl/qtmr_pkg.sv
package qtmr_pkg;

  // control register bit positions
  localparam int CTL_EN   = 7;
  localparam int CTL_PER  = 6;
  localparam int CTL_PSH  = 3;
  localparam int CTL_PSL  = 2;
  localparam int CTL_WIDE = 1;
  localparam int CTL_OS   = 0;

  typedef enum logic [1:0] {
    PS_DIV1   = 2'b00,
    PS_DIV16  = 2'b01,
    PS_DIV256 = 2'b10
  } ps_sel_e;

  typedef struct packed {
    logic       en;
    logic       per;
    logic [1:0] ps;
    logic       wide;
    logic       os;
  } ctl_t;

  function automatic logic [7:0] ctl_word(input ctl_t c);
    logic [7:0] w;
    w            = '0;
    w[CTL_EN]    = c.en;
    w[CTL_PER]   = c.per;
    w[CTL_PSH:CTL_PSL] = c.ps;
    w[CTL_WIDE]  = c.wide;
    w[CTL_OS]    = c.os;
    return w;
  endfunction

endpackage

// File: rtl/qtmr_prescale.sv
module qtmr_prescale #(
  parameter int MID_LOG2 = 4,
  parameter int TOP_LOG2 = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  import qtmr_pkg::*;

  logic [TOP_LOG2-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pc_q <= '0;
    else if (!run || restart) pc_q <= '0;
    else                      pc_q <= pc_q + 1'b1;
  end

  always_comb begin
    unique case (sel)
      PS_DIV1:  tick = run;
      PS_DIV16: tick = run && (pc_q[MID_LOG2-1:0] == '1);
      default:  tick = run && (pc_q == '1);
    endcase
  end

endmodule

// File: rtl/qtmr_channel.sv
module qtmr_channel #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_load,
  input  logic          wr_bg,
  input  logic          wr_ctl,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] bg_o,
  output qtmr_pkg::ctl_t ctl_o,
  output logic          zero_ev
);
  import qtmr_pkg::*;

  localparam int HALF = CW / 2;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, bg_q, cur, bg_fit, top_val, nxt;
  ctl_t          ctl_q;
  logic          tick, halt;

  qtmr_prescale #(.MID_LOG2(4), .TOP_LOG2(8)) u_ps (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctl_q.en),
    .restart (wr_load),
    .sel     (ctl_q.ps),
    .tick    (tick)
  );

  always_comb begin
    if (ctl_q.wide) begin
      cur     = cnt_q;
      bg_fit  = bg_q;
      top_val = '1;
    end else begin
      cur     = {{(CW-HALF){1'b0}}, cnt_q[HALF-1:0]};
      bg_fit  = {{(CW-HALF){1'b0}}, bg_q[HALF-1:0]};
      top_val = {{(CW-HALF){1'b0}}, {HALF{1'b1}}};
    end
    if (cur != '0)       nxt = cur - ONE;
    else if (ctl_q.os)   nxt = '0;
    else if (ctl_q.per)  nxt = bg_fit;
    else                 nxt = top_val;
  end

  assign halt    = tick && ctl_q.os && (cur == '0 || cur == ONE);
  assign zero_ev = tick && (cur == ONE || (cur == '0 && ctl_q.os));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bg_q  <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_ctl) begin
        ctl_q.en   <= wdata[CTL_EN];
        ctl_q.per  <= wdata[CTL_PER];
        ctl_q.ps   <= wdata[CTL_PSH:CTL_PSL];
        ctl_q.wide <= wdata[CTL_WIDE];
        ctl_q.os   <= wdata[CTL_OS];
      end else if (halt) begin
        ctl_q.en <= 1'b0;
      end
      if (wr_load) begin
        cnt_q <= wdata;
        bg_q  <= wdata;
      end else begin
        if (wr_bg) bg_q  <= wdata;
        if (tick)  cnt_q <= nxt;
      end
    end
  end

  assign cnt_o = cur;
  assign bg_o  = bg_q;
  assign ctl_o = ctl_q;

endmodule

// File: rtl/quad_dtimer.sv
module quad_dtimer #(
  parameter int NCH = 4,
  parameter int CW  = 32,
  parameter int AW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          irq_o
);
  import qtmr_pkg::*;

  localparam int GW      = AW - 4;
  localparam int W_MASK  = 0;
  localparam int W_RAW   = 1;
  localparam int W_MIS   = 2;
  localparam int W_CLR   = 3;
  localparam int W_LOAD  = 0;
  localparam int W_VAL   = 1;
  localparam int W_CTL   = 2;
  localparam int W_BG    = 3;

  logic [GW-1:0]   grp;
  logic [1:0]      word;
  logic            aligned, shared_sel;
  logic [NCH-1:0]  mask_q, raw_q, clr_bits, ev_v, en_v, os_v, wide_v;
  logic [CW-1:0]   cnt_a [NCH];
  logic [CW-1:0]   bg_a  [NCH];
  ctl_t            ctl_a [NCH];
  logic [NCH*CW-1:0] cnt_flat;

  assign grp        = bus_addr[AW-1:4];
  assign word       = bus_addr[3:2];
  assign aligned    = (bus_addr[1:0] == 2'b00);
  assign shared_sel = aligned && (grp == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = aligned && (grp == GW'(i + 1));
    qtmr_channel #(.CW(CW)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_load (bus_wr && sel && word == 2'(W_LOAD)),
      .wr_bg   (bus_wr && sel && word == 2'(W_BG)),
      .wr_ctl  (bus_wr && sel && word == 2'(W_CTL)),
      .wdata   (bus_wdata),
      .cnt_o   (cnt_a[i]),
      .bg_o    (bg_a[i]),
      .ctl_o   (ctl_a[i]),
      .zero_ev (ev_v[i])
    );
    assign en_v[i]   = ctl_a[i].en;
    assign os_v[i]   = ctl_a[i].os;
    assign wide_v[i] = ctl_a[i].wide;
    assign cnt_flat[i*CW +: CW] = cnt_a[i];
  end

  assign clr_bits = (bus_wr && shared_sel && word == 2'(W_CLR)) ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      raw_q  <= '0;
    end else begin
      if (bus_wr && shared_sel && word == 2'(W_MASK)) mask_q <= bus_wdata[NCH-1:0];
      raw_q <= (raw_q & ~clr_bits) | ev_v;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (shared_sel) begin
      case (word)
        2'(W_MASK): bus_rdata = CW'(mask_q);
        2'(W_RAW):  bus_rdata = CW'(raw_q);
        2'(W_MIS):  bus_rdata = CW'(raw_q & mask_q);
        default:    bus_rdata = '0;
      endcase
    end
    for (int i = 0; i < NCH; i++) begin
      if (aligned && grp == GW'(i + 1)) begin
        case (word)
          2'(W_LOAD), 2'(W_VAL): bus_rdata = cnt_a[i];
          2'(W_CTL):             bus_rdata = CW'(ctl_word(ctl_a[i]));
          default:               bus_rdata = bg_a[i];
        endcase
      end
    end
  end

  assign irq_o = |(raw_q & mask_q);

endmodule

// File: rtl/qtmr_chk.sv
module qtmr_chk #(
  parameter int NCH = 4,
  parameter int CW  = 32,
  parameter int AW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     bus_addr,
  input logic              bus_wr,
  input logic [NCH-1:0]    wdata_lo,
  input logic [CW-1:CW/2]  rdata_hi,
  input logic              irq_o,
  input logic [NCH-1:0]    raw_q,
  input logic [NCH-1:0]    mask_q,
  input logic [NCH-1:0]    ev_v,
  input logic [NCH-1:0]    en_v,
  input logic [NCH-1:0]    os_v,
  input logic [NCH-1:0]    wide_v,
  input logic [NCH*CW-1:0] cnt_flat
);
  localparam logic [AW-1:0] CLR_ADDR = AW'(12);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);

  for (genvar i = 0; i < NCH; i++) begin : g_c
    localparam logic [AW-1:0] VAL_ADDR = AW'(16 + 16 * i + 4);

    // R8
    raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_v[i] |=> raw_q[i]);

    // R10
    raw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == CLR_ADDR && wdata_lo[i] && !ev_v[i]) |=> !raw_q[i]);

    // R6
    oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_v[i] && os_v[i]) && !en_v[i] && !$past(bus_wr))
        |-> (cnt_flat[i*CW +: CW] == '0));

    // R7
    narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == VAL_ADDR && !wide_v[i]) |-> (rdata_hi == '0));
  end

endmodule

bind quad_dtimer qtmr_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .wdata_lo (bus_wdata[NCH-1:0]),
  .rdata_hi (bus_rdata[CW-1:CW/2]),
  .irq_o    (irq_o),
  .raw_q    (raw_q),
  .mask_q   (mask_q),
  .ev_v     (ev_v),
  .en_v     (en_v),
  .os_v     (os_v),
  .wide_v   (wide_v),
  .cnt_flat (cnt_flat)
);

// File: tb/quad_dtimer_tb.sv
module quad_dtimer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  always #4 clk = ~clk;

  quad_dtimer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  typedef struct {
    logic [31:0] exp;
    bit          is_irq;
    logic [7:0]  addr;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int    nvec = 0;
  int    nmis = 0;
  bit    mon_go = 1'b0;
  bit    done = 1'b0;

  // monitor: pops the scoreboard and compares against the port
  always begin
    @(negedge clk);
    #1;
    if (mon_go && sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {31'b0, irq_o} : bus_rdata;
      nvec++;
      if (act !== it.exp) begin
        nmis++;
        $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h",
                 it.tag, it.addr, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.exp = e; it.is_irq = 1'b0; it.addr = a; it.tag = tag;
    sb_q.push_back(it);
    mon_go = 1'b1;
    @(posedge clk);
    mon_go = 1'b0;
  endtask

  task automatic irq_is(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = {31'b0, e}; it.is_irq = 1'b1; it.addr = bus_addr; it.tag = tag;
    sb_q.push_back(it);
    mon_go = 1'b1;
    @(posedge clk);
    mon_go = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nmis++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11 reset state
    rd(8'h18, 32'h0, "R11 ctl0");
    rd(8'h04, 32'h0, "R11 raw");
    rd(8'h00, 32'h0, "R11 mask");
    irq_is(1'b0, "R11 irq");

    // R2 load copies to background; background write leaves count
    wr(8'h10, 32'h100);
    rd(8'h14, 32'h100, "R2 count");
    rd(8'h1C, 32'h100, "R2 bg copy");
    wr(8'h1C, 32'h77);
    rd(8'h14, 32'h100, "R2 count kept");
    rd(8'h1C, 32'h77, "R2 bg written");

    // R4 / R3 free-running, divide by 1, 32 bit
    wr(8'h10, 32'd3);
    wr(8'h18, 32'h82);
    rd(8'h14, 32'd3, "R3 first");
    rd(8'h14, 32'd2, "R3 tick");
    rd(8'h14, 32'd1, "R3 tick");
    rd(8'h14, 32'd0, "R3 zero");
    rd(8'h14, 32'hFFFF_FFFF, "R4 wrap32");
    rd(8'h04, 32'h1, "R8 raw bit0");
    rd(8'h08, 32'h0, "R9 masked off");
    irq_is(1'b0, "R9 irq masked");
    wr(8'h00, 32'h1);
    rd(8'h08, 32'h1, "R9 masked on");
    irq_is(1'b1, "R9 irq");
    rd(8'h00, 32'h1, "R1 mask rw");
    wr(8'h0C, 32'h0);
    rd(8'h04, 32'h1, "R10 zero bits");
    wr(8'h0C, 32'h1);
    rd(8'h04, 32'h0, "R10 cleared");
    irq_is(1'b0, "R10 irq low");
    rd(8'h0C, 32'h0, "R1 clr reads 0");
    wr(8'h18, 32'h0);

    // R1 unmapped, misaligned; R8 raw read-only
    rd(8'h80, 32'h0, "R1 unmapped");
    rd(8'h1D, 32'h0, "R1 misaligned");
    wr(8'h04, 32'hF);
    rd(8'h04, 32'h0, "R8 raw ignores write");

    // R7 16-bit counting on channel 2
    wr(8'h38, 32'h0);
    wr(8'h30, 32'h1_0002);
    rd(8'h34, 32'h2, "R7 upper hidden");
    wr(8'h38, 32'h80);
    rd(8'h34, 32'h2, "R7 first");
    rd(8'h34, 32'h1, "R7 tick");
    rd(8'h34, 32'h0, "R7 zero");
    rd(8'h34, 32'hFFFF, "R7 wrap16");
    rd(8'h04, 32'h4, "R8 raw bit2");
    wr(8'h38, 32'h0);
    wr(8'h0C, 32'hF);

    // R5 periodic on channel 1
    wr(8'h20, 32'd2);
    wr(8'h2C, 32'd5);
    rd(8'h24, 32'd2, "R5 bg not disturbing");
    wr(8'h28, 32'hC2);
    rd(8'h24, 32'd2, "R5 first");
    rd(8'h24, 32'd1, "R5 tick");
    rd(8'h24, 32'd0, "R5 zero");
    rd(8'h24, 32'd5, "R5 reload");
    rd(8'h24, 32'd4, "R5 after reload");
    rd(8'h04, 32'h2, "R8 raw bit1");
    rd(8'h28, 32'hC2, "R1 ctl readback");
    wr(8'h28, 32'h0);
    wr(8'h0C, 32'hF);

    // R6 one-shot with periodic also set on channel 3
    wr(8'h40, 32'd2);
    wr(8'h48, 32'hC3);
    rd(8'h44, 32'd2, "R6 first");
    rd(8'h44, 32'd1, "R6 tick");
    rd(8'h44, 32'd0, "R6 zero");
    rd(8'h44, 32'd0, "R6 halted");
    rd(8'h48, 32'h43, "R6 enable cleared");
    rd(8'h04, 32'h8, "R8 raw bit3");
    wr(8'h0C, 32'hF);

    // R3 divide by 16 on channel 0
    wr(8'h10, 32'd4);
    wr(8'h18, 32'h86);
    step(15);
    rd(8'h14, 32'd4, "R3 div16 before");
    rd(8'h14, 32'd3, "R3 div16 tick");

    // R3 divide by 256 on channel 0
    wr(8'h18, 32'h0);
    wr(8'h10, 32'd1);
    wr(8'h18, 32'h8A);
    step(255);
    rd(8'h14, 32'd1, "R3 div256 before");
    rd(8'h14, 32'd0, "R3 div256 tick");
    rd(8'h04, 32'h1, "R8 raw after div256");

    step(2);
    done = 1'b1;
    report();
  end

endmodule